// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the two-wire management bus between a network controller and an external PHY. A host asks for one register access at a time: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block builds the serial frame and toggles a management clock (MDC) derived from the system clock. It drives or releases a tri-state data line (MDIO), which appears as a separate output value, output enable and input. When the frame ends it returns the read data and a read-error flag, with a one-cycle done pulse.

The block watches the PHY's turnaround response to spot reads that got no answer. It also tracks whether the PHY can work without the preamble and drops the 32-bit preamble once it knows. While the bus is idle it samples the level that an external resistor network puts on the released line, and from that level it reports whether a PHY is attached.

Top module: `mdio_master`

## Requirements
- R1: A full frame has 65 MDC bit periods in this order: 32 ones, start bits 0,1, an opcode (1,0 = read, 0,1 = write), the PHY address, the register address, 2 turnaround bits, 16 data bits, then one idle bit with MDIO released. Every field is sent MSB first.
- R2: On a write the master drives the turnaround as 1 then 0, followed by the write data. On a read it releases MDIO (output enable 0) for both turnaround bits and all 16 data bits.
- R3: On a read, a 1 sampled in the second turnaround bit sets rd_err at done, and the suppression state is cleared. A 0 there gives rd_err = 0. rd_err is 0 after every write.
- R4: While no frame is in progress, MDC is 0 and the MDIO output enable is 0.
- R5: rate_sel picks the MDC half-period in system clocks: 00 and 11 give 10 (2.5 MHz at 50 MHz), 01 gives 5, 10 gives 2. The setting is latched when a request is accepted.
- R6: MDIO changes only with a falling MDC edge. Read bits are sampled on rising edges, and rd_data holds the 16 data bits with the first bit received in bit 15.
- R7: A read of register 1 with no error and a 1 in returned data bit 6 sets pre_sup. While pre_sup is 1, frames start at the start bits and take 33 bit periods.
- R8: pre_sup is 0 after reset. It is cleared by a read error and when phy_present falls.
- R9: While idle, phy_present follows the level on the released MDIO line (1 = attached), through a two-stage synchronizer. Each change gives exactly one one-cycle present_evt pulse.
- R10: A request is accepted only when ready is 1 (idle). Requests made while busy are ignored and do not change the frame in progress.
- R11: done pulses for one cycle, 2·half·bits system clocks after the accepting edge, at the falling MDC edge that ends the idle bit. ready returns to 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rate_sel | input | 2 | MDC rate select |
| ready | output | 1 | Idle, request will be accepted |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read data |
| rd_err | output | 1 | Last read had a turnaround error |
| pre_sup | output | 1 | Preamble suppression active |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input level |
| phy_present | output | 1 | PHY attached status |
| present_evt | output | 1 | One-cycle pulse on presence change |

## Verification
Writes are swept over all 32 register addresses, each paired with a different PHY address and data word. A field swapped or sent in the wrong order therefore shows up in the bit-by-bit frame capture. Reads use all-zero, all-one, single-edge-bit and mixed patterns, which separate shift direction and sampling edge errors. The turnaround is answered with 0, with 1, and left to the pull-up, so a good read can be told apart from both kinds of failure. Each of the four rate codes is tried with frame length timing, and preamble suppression is entered and then left by a read error and by PHY loss. This shows the 33-bit and 65-bit frame lengths and which events switch between them.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_req_t;

  localparam logic [6:0] POS_START = 7'd32;  // first bit after preamble
  localparam logic [6:0] POS_TA1   = 7'd46;
  localparam logic [6:0] POS_TA2   = 7'd47;
  localparam logic [6:0] POS_DATA  = 7'd48;
  localparam logic [6:0] POS_IDLE  = 7'd64;
  localparam logic [4:0] STATUS_REG = 5'd1;
  localparam int unsigned SUP_BIT  = 6;

  function automatic logic [31:0] make_hdr(input mdio_req_t r);
    return {2'b01, (r.wr ? 2'b01 : 2'b10), r.phy, r.regad,
            (r.wr ? 2'b10 : 2'b00), (r.wr ? r.wdata : 16'h0000)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned HALF_SLOW = 10,
  parameter int unsigned HALF_MID  = 5,
  parameter int unsigned HALF_FAST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       mdc,
  output logic       rise_en,
  output logic       fall_en
);
  localparam int unsigned CW = $clog2(HALF_SLOW);

  logic [CW-1:0] cnt_q, cnt_d, term;
  logic          mdc_q, mdc_d, at_term;

  always_comb begin
    case (rate)
      2'b01:   term = CW'(HALF_MID - 1);
      2'b10:   term = CW'(HALF_FAST - 1);
      default: term = CW'(HALF_SLOW - 1);
    endcase
    at_term = run && (cnt_q == term);
    rise_en = at_term && !mdc_q;
    fall_en = at_term && mdc_q;
    cnt_d   = (!run || at_term) ? '0 : cnt_q + 1'b1;
    mdc_d   = !run ? 1'b0 : (at_term ? !mdc_q : mdc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R5: MDC only toggles after a full half-period count
  p_toggle_at_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(mdc_q)) |-> ($past(cnt_q) == $past(term)));
endmodule

// File: rtl/mdio_presence.sv
module mdio_presence (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic line_i,
  output logic present,
  output logic present_evt
);
  logic s1_q, s2_q, pres_q, pres_d, evt_q, evt_d;

  always_comb begin
    pres_d = pres_q;
    evt_d  = 1'b0;
    if (sample_en && (s2_q != pres_q)) begin
      pres_d = s2_q;
      evt_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      pres_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      pres_q <= pres_d;
      evt_q  <= evt_d;
    end
  end

  assign present     = pres_q;
  assign present_evt = evt_q;

  // R9: an event pulse always coincides with a status change
  p_evt_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    present_evt |-> (present != $past(present)));
  p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    present_evt |=> !present_evt);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_SLOW = 10,
  parameter int unsigned HALF_MID  = 5,
  parameter int unsigned HALF_FAST = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  rate_sel,
  output logic        ready,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        pre_sup,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        phy_present,
  output logic        present_evt
);
  logic        busy_q, busy_d, wr_q, wr_d, ta_err_q, ta_err_d;
  logic        done_q, done_d, err_q, err_d, sup_q, sup_d;
  logic [6:0]  pos_q, pos_d;
  logic [31:0] hdr_q, hdr_d;
  logic [4:0]  reg_q, reg_d, hidx;
  logic [1:0]  rate_q, rate_d;
  logic [15:0] rdsh_q, rdsh_d, rdat_q, rdat_d;
  logic        rise_en, fall_en, accept;
  mdio_req_t   req;

  mdio_clkgen #(.HALF_SLOW(HALF_SLOW), .HALF_MID(HALF_MID), .HALF_FAST(HALF_FAST))
    u_clkgen (.clk(clk), .rst_n(rst_n), .run(busy_q), .rate(rate_q),
              .mdc(mdc), .rise_en(rise_en), .fall_en(fall_en));

  mdio_presence u_presence (.clk(clk), .rst_n(rst_n), .sample_en(!busy_q),
                            .line_i(mdio_i), .present(phy_present),
                            .present_evt(present_evt));

  always_comb begin
    req    = '{wr: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
    accept = req_valid && !busy_q;
    busy_d = busy_q;  pos_d = pos_q;  hdr_d = hdr_q;  wr_d = wr_q;
    reg_d  = reg_q;   rate_d = rate_q; ta_err_d = ta_err_q;
    rdsh_d = rdsh_q;  rdat_d = rdat_q; err_d = err_q; sup_d = sup_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d   = 1'b1;
      pos_d    = sup_q ? POS_START : 7'd0;
      hdr_d    = make_hdr(req);
      wr_d     = req_write;
      reg_d    = req_reg;
      rate_d   = rate_sel;
      ta_err_d = 1'b0;
    end
    if (busy_q && rise_en && !wr_q) begin
      if (pos_q == POS_TA2) ta_err_d = mdio_i;
      if (pos_q >= POS_DATA && pos_q < POS_IDLE) rdsh_d = {rdsh_q[14:0], mdio_i};
    end
    if (busy_q && fall_en) begin
      if (pos_q == POS_IDLE) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        if (!wr_q) begin
          rdat_d = rdsh_q;
          err_d  = ta_err_q;
          if (ta_err_q) sup_d = 1'b0;
          else if (reg_q == STATUS_REG && rdsh_q[SUP_BIT]) sup_d = 1'b1;
        end else begin
          err_d = 1'b0;
        end
      end else begin
        pos_d = pos_q + 7'd1;
      end
    end
    if (present_evt && !phy_present) sup_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;  pos_q <= '0;  hdr_q <= '0;  wr_q <= 1'b0;
      reg_q <= '0;  rate_q <= '0;  ta_err_q <= 1'b0;  rdsh_q <= '0;
      rdat_q <= '0;  done_q <= 1'b0;  err_q <= 1'b0;  sup_q <= 1'b0;
    end else begin
      busy_q <= busy_d;  pos_q <= pos_d;  hdr_q <= hdr_d;  wr_q <= wr_d;
      reg_q <= reg_d;  rate_q <= rate_d;  ta_err_q <= ta_err_d;  rdsh_q <= rdsh_d;
      rdat_q <= rdat_d;  done_q <= done_d;  err_q <= err_d;  sup_q <= sup_d;
    end
  end

  always_comb begin
    hidx    = 5'(7'd63 - pos_q);
    mdio_o  = (pos_q < POS_START) ? 1'b1 : hdr_q[hidx];
    mdio_oe = busy_q && (pos_q != POS_IDLE) && !(!wr_q && pos_q >= POS_TA1);
  end

  assign ready   = !busy_q;
  assign done    = done_q;
  assign rd_data = rdat_q;
  assign rd_err  = err_q;
  assign pre_sup = sup_q;

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready);
  p_err_clears_sup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_err) |-> !pre_sup);
  p_change_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] rate_sel = 2'b00;
  logic ready, done, rd_err, pre_sup, mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_present, present_evt;
  logic [15:0] rd_data;
  logic pull_hi = 1'b1, phy_drv = 1'b0, phy_val = 1'b0;

  int n_tests = 0, n_fail = 0, cyc = 0, evt_cnt = 0;
  int m_start = 0, m_ta = 0, rise_cnt = 0, fall_cnt = 0;
  bit m_read = 0;
  logic [15:0] m_data = '0;
  logic cap_o [0:64];
  logic cap_oe[0:64];

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (present_evt) evt_cnt <= evt_cnt + 1;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : pull_hi);

  mdio_master i_mdio_master (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rate_sel(rate_sel), .ready(ready), .done(done),
    .rd_data(rd_data), .rd_err(rd_err), .pre_sup(pre_sup), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .phy_present(phy_present), .present_evt(present_evt));

  // Capture each bit on the rising MDC edge
  always @(posedge mdc) begin
    if (rise_cnt < 65) begin
      cap_o[rise_cnt]  = mdio_o;
      cap_oe[rise_cnt] = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  // PHY model: answers a read after each falling MDC edge
  always @(negedge mdc) begin
    int p;
    p = m_start + fall_cnt;
    fall_cnt = fall_cnt + 1;
    if (m_read && m_ta != 2) begin
      if (p == 46) begin phy_drv = 1'b1; phy_val = (m_ta == 1); end
      else if (p >= 47 && p <= 62) begin phy_drv = 1'b1; phy_val = m_data[62-p]; end
      else if (p == 63) phy_drv = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] r);
    return (r == 2'b01) ? 5 : (r == 2'b10) ? 2 : 10;
  endfunction

  // ta_mode: 0 PHY drives 0, 1 PHY drives 1, 2 PHY silent
  task automatic do_frame(input bit wr, input logic [4:0] ph, input logic [4:0] rg,
                          input logic [15:0] wd, input logic [15:0] pdat,
                          input int ta_mode, input bit exp_pre, input bit poke);
    int c0, nbits, half, bad, start;
    start = exp_pre ? 0 : 32;
    nbits = exp_pre ? 65 : 33;
    half = half_of(rate_sel);
    m_read = !wr; m_start = start; m_data = pdat; m_ta = ta_mode;
    rise_cnt = 0; fall_cnt = 0; phy_drv = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = ph; req_reg = rg; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    c0 = cyc;
    chk(!ready, "R10", "ready after accept", ready, 0);
    while (!done && cyc < c0 + 20000) begin
      @(negedge clk);
      if (poke && cyc == c0 + 30) begin
        req_valid = 1'b1; req_write = !wr; req_phy = ~ph; req_reg = ~rg; req_wdata = ~wd;
      end else req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk(cyc - c0 == 2*half*nbits, "R11/R5", "done delay", cyc - c0, 2*half*nbits);
    chk(ready, "R11", "ready at done", ready, 1);
    chk(rise_cnt == nbits, "R1/R7", "bit count", rise_cnt, nbits);
    bad = 0;
    for (int k = 0; k < nbits && k < 65; k++) begin
      int p;
      logic eo, ev;
      p = start + k; eo = 1'b1; ev = 1'b1;
      if (p < 32) ev = 1'b1;
      else if (p == 32) ev = 1'b0;
      else if (p == 33) ev = 1'b1;
      else if (p == 34) ev = !wr;
      else if (p == 35) ev = wr;
      else if (p <= 40) ev = ph[40-p];
      else if (p <= 45) ev = rg[45-p];
      else if (p == 64) eo = 1'b0;
      else if (!wr) eo = 1'b0;
      else if (p == 46) ev = 1'b1;
      else if (p == 47) ev = 1'b0;
      else ev = wd[63-p];
      if (cap_oe[k] !== eo || (eo && cap_o[k] !== ev)) bad++;
    end
    chk(bad == 0, wr ? "R1/R2" : "R1/R2 read", "mismatched bits", bad, 0);
    chk(!mdc && !mdio_oe, "R4", "idle mdc/oe", {mdc, mdio_oe}, 0);
    if (!wr) begin
      chk(rd_err == (ta_mode != 0), "R3", "rd_err", rd_err, ta_mode != 0);
      if (ta_mode == 0) chk(rd_data == pdat, "R6", "rd_data", rd_data, pdat);
    end else chk(!rd_err, "R3", "rd_err after write", rd_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && !done && !mdc && !mdio_oe && !pre_sup, "R4/R8", "reset state",
        {ready, done, mdc, mdio_oe, pre_sup}, 5'b10000);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(phy_present, "R9", "present after reset", phy_present, 1);

    // R5: every rate code
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      do_frame(1'b1, 5'h11, 5'h0A, 16'hC3A5, 16'h0, 0, 1'b1, 1'b0);
    end

    // R1: address / data sweep at the fast rate
    rate_sel = 2'b10;
    for (int a = 0; a < 32; a++)
      do_frame(1'b1, 5'(31 - a), 5'(a), 16'(a * 16'h0841) ^ 16'hA5C3, 16'h0, 0, 1'b1, 1'b0);

    // R6: read patterns, no suppression (register 1 with bit 6 clear)
    do_frame(1'b0, 5'h01, 5'h02, 16'h0, 16'h0000, 0, 1'b1, 1'b0);
    do_frame(1'b0, 5'h1F, 5'h03, 16'h0, 16'hFFFF, 0, 1'b1, 1'b0);
    do_frame(1'b0, 5'h05, 5'h10, 16'h0, 16'h8001, 0, 1'b1, 1'b0);
    do_frame(1'b0, 5'h0A, 5'h01, 16'h0, 16'hFFBF, 0, 1'b1, 1'b0);
    chk(!pre_sup, "R7", "no suppression without bit 6", pre_sup, 0);

    // R7: valid status read with bit 6 set
    do_frame(1'b0, 5'h0A, 5'h01, 16'h0, 16'h5A7C, 0, 1'b1, 1'b0);
    chk(pre_sup, "R7", "suppression set", pre_sup, 1);
    do_frame(1'b1, 5'h03, 5'h04, 16'h1234, 16'h0, 0, 1'b0, 1'b0);
    do_frame(1'b0, 5'h03, 5'h12, 16'h0, 16'h3C5A, 0, 1'b0, 1'b0);

    // R10: request while busy is ignored
    do_frame(1'b1, 5'h06, 5'h07, 16'hBEEF, 16'h0, 0, 1'b0, 1'b1);

    // R3/R8: turnaround driven 1 -> error, preamble restored
    do_frame(1'b0, 5'h03, 5'h05, 16'h0, 16'h1111, 1, 1'b0, 1'b0);
    chk(!pre_sup, "R8", "suppression cleared by error", pre_sup, 0);
    do_frame(1'b0, 5'h03, 5'h05, 16'h0, 16'h2222, 2, 1'b1, 1'b0);
    do_frame(1'b0, 5'h03, 5'h05, 16'h0, 16'h2222, 0, 1'b1, 1'b0);

    // R8/R9: PHY removal clears suppression
    do_frame(1'b0, 5'h03, 5'h01, 16'h0, 16'h0040, 0, 1'b1, 1'b0);
    chk(pre_sup, "R7", "suppression set again", pre_sup, 1);
    @(negedge clk); evt_cnt = 0; pull_hi = 1'b0;
    repeat (8) @(negedge clk);
    chk(!phy_present, "R9", "present after removal", phy_present, 0);
    chk(evt_cnt == 1, "R9", "event pulses on removal", evt_cnt, 1);
    chk(!pre_sup, "R8", "suppression cleared by removal", pre_sup, 0);
    evt_cnt = 0; pull_hi = 1'b1;
    repeat (8) @(negedge clk);
    chk(phy_present && evt_cnt == 1, "R9", "present/event on attach",
        {phy_present, 8'(evt_cnt)}, 9'h101);
    do_frame(1'b1, 5'h02, 5'h09, 16'h0F0F, 16'h0, 0, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule